// File: doc/BRIEF.md
# Block Transfer / Compare Repeat Controller

This block decides whether a block transfer or block compare instruction ends or runs again. It does not access memory and does no compare arithmetic. It is given the 16-bit byte counter, the program counter, a repeat-mode bit, the zero flag from the compare and a flag that says which of the two instruction kinds is running. From these it produces the decremented counter, the parity/overflow flag and the new program counter and memptr value. It also sequences the cycles that lead to the next opcode fetch.

One `start` pulse, given while the block is idle, captures all the inputs. The next cycle, ST_DECIDE, writes back the counter minus one and sets the flag when that result is nonzero. It also makes the repeat decision.

Each transition is named below:
- **ST_IDLE → ST_DECIDE** (on `start`).
- **Short ending, ST_DECIDE → ST_WAITCHK.** The block goes straight to the wait-state check.
- **Long ending, ST_DECIDE → ST_STALL.** The program counter is rewound by two and memptr gets the rewound PC plus one. The block then spends exactly five cycles in ST_STALL, and during these the address bus is told to show the pointer register's high byte.
- **ST_STALL → ST_WAITCHK** after those five cycles.
- **ST_WAITCHK → ST_WAITCHK** while the wait input is high.
- **ST_WAITCHK → ST_FETCH** once the wait input is low.
- **ST_FETCH → ST_IDLE.** ST_FETCH raises the fetch strobe and the done pulse for one cycle, then the block returns to ST_IDLE.

Top module: `blkrep_ctrl`

## Requirements
- R1: In the cycle after ST_DECIDE, `bc_out` equals the captured counter minus one, modulo 2^16 (0x0000 becomes 0xFFFF).
- R2: In the same cycle, `pv_flag` is 1 exactly when the decremented counter is nonzero.
- R3: When `is_cmp`=0 (transfer), the long ending is taken only if `rep_mode`=1 and the decremented counter is nonzero.
- R4: When `is_cmp`=1 (compare), the long ending is taken only if `rep_mode`=1, the decremented counter is nonzero and `zf_in`=0.
- R5: On the long ending, `pc_out` = captured PC − 2 and `memptr_out` = captured PC − 1, both modulo 2^16.
- R6: The long ending holds `addr_hi_sel` high for exactly 5 cycles. `done` rises 8 cycles after the `start` edge, against 3 cycles for the short ending when there is no wait.
- R7: On the short ending, `pc_out` keeps the captured PC and `memptr_out` keeps its previous value. `addr_hi_sel` stays low.
- R8: In ST_WAITCHK, each cycle with `wait_in`=1 delays `fetch_go`/`done` by one cycle.
- R9: After reset every output is 0. `busy` is high from the cycle after `start` up to and including the single `done`/`fetch_go` cycle, and low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a decision (taken only while idle) |
| is_cmp | input | 1 | 1 = compare instruction, 0 = transfer |
| rep_mode | input | 1 | 1 = repeating form of the instruction |
| zf_in | input | 1 | Zero flag from the compare |
| bc_in | input | 16 | Byte counter before this iteration |
| pc_in | input | 16 | Program counter of the following instruction |
| wait_in | input | 1 | Wait-state request checked before the fetch |
| bc_out | output | 16 | Counter after decrement |
| pv_flag | output | 1 | Counter-nonzero flag |
| pc_out | output | 16 | Program counter after the decision |
| memptr_out | output | 16 | Internal memptr register |
| addr_hi_sel | output | 1 | Address bus shows pointer high byte (stall cycles) |
| busy | output | 1 | Sequence in progress |
| repeat_taken | output | 1 | Last decision took the long ending |
| fetch_go | output | 1 | Opcode fetch begins this cycle |
| done | output | 1 | Final cycle of either ending |

## Verification
Two termination causes can meet in one compare iteration: the decremented counter reaching zero, and the zero flag being set. The bench provokes this with a counter of 1, `zf_in`=1 and repeat mode on. It expects the short 3-cycle ending with the flag cleared, the PC untouched and no stall cycles. A wait request that overlaps the end of the short ending is also checked, by measuring the exact delay of the done pulse.

// File: rtl/blkrep_pkg.sv
package blkrep_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_STALL,
        ST_WAITCHK,
        ST_FETCH
    } rep_state_e;
endpackage

// File: rtl/blkrep_decide.sv
module blkrep_decide #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             is_cmp,
    input  logic             rep_mode,
    input  logic             zf,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_nz,
    output logic             do_repeat
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        cnt_next  = cnt_in - ONE;
        cnt_nz    = |cnt_next;
        do_repeat = rep_mode && cnt_nz && !(is_cmp && zf);
    end
endmodule

// File: rtl/blkrep_stall.sv
module blkrep_stall #(
    parameter int CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic last
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load)   cnt_q <= '0;
        else if (run && cnt_q != LAST_V) cnt_q <= cnt_q + CW'(1);
    end

    assign last = (cnt_q == LAST_V);
endmodule

// File: rtl/blkrep_ctrl.sv
module blkrep_ctrl
    import blkrep_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int ADDR_W     = 16,
    parameter int STALL_CYC  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_cmp,
    input  logic              rep_mode,
    input  logic              zf_in,
    input  logic [CNT_W-1:0]  bc_in,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic              wait_in,
    output logic [CNT_W-1:0]  bc_out,
    output logic              pv_flag,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] memptr_out,
    output logic              addr_hi_sel,
    output logic              busy,
    output logic              repeat_taken,
    output logic              fetch_go,
    output logic              done
);
    localparam logic [ADDR_W-1:0] REWIND = ADDR_W'(2);
    localparam int HW = $clog2(STALL_CYC + 2);

    rep_state_e state_q, state_d;

    logic [CNT_W-1:0]  bc_q;
    logic [ADDR_W-1:0] pc_q, mp_q;
    logic              cmp_q, rep_q, zf_q, pv_q, taken_q;

    logic [CNT_W-1:0]  bc_next;
    logic              bc_nz, go_long, stall_last;

    blkrep_decide #(.CNT_W(CNT_W)) u_decide (
        .cnt_in    (bc_q),
        .is_cmp    (cmp_q),
        .rep_mode  (rep_q),
        .zf        (zf_q),
        .cnt_next  (bc_next),
        .cnt_nz    (bc_nz),
        .do_repeat (go_long)
    );

    blkrep_stall #(.CYCLES(STALL_CYC)) u_stall (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state_q == ST_DECIDE),
        .run   (state_q == ST_STALL),
        .last  (stall_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_DECIDE;
            ST_DECIDE:  state_d = go_long ? ST_STALL : ST_WAITCHK;
            ST_STALL:   if (stall_last) state_d = ST_WAITCHK;
            ST_WAITCHK: if (!wait_in) state_d = ST_FETCH;
            ST_FETCH:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            bc_q    <= '0;
            pc_q    <= '0;
            mp_q    <= '0;
            cmp_q   <= 1'b0;
            rep_q   <= 1'b0;
            zf_q    <= 1'b0;
            pv_q    <= 1'b0;
            taken_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                bc_q  <= bc_in;
                pc_q  <= pc_in;
                cmp_q <= is_cmp;
                rep_q <= rep_mode;
                zf_q  <= zf_in;
            end
            if (state_q == ST_DECIDE) begin
                bc_q    <= bc_next;
                pv_q    <= bc_nz;
                taken_q <= go_long;
                if (go_long) begin
                    pc_q <= pc_q - REWIND;
                    mp_q <= pc_q - REWIND + ADDR_W'(1);
                end
            end
        end
    end

    // outputs
    always_comb begin
        bc_out       = bc_q;
        pv_flag      = pv_q;
        pc_out       = pc_q;
        memptr_out   = mp_q;
        repeat_taken = taken_q;
        addr_hi_sel  = (state_q == ST_STALL);
        busy         = (state_q != ST_IDLE);
        fetch_go     = (state_q == ST_FETCH);
        done         = (state_q == ST_FETCH);
    end

    // checker state: length of the current stall run
    logic [HW-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hi_run_q <= '0;
        else if (state_q == ST_DECIDE) hi_run_q <= '0;
        else if (addr_hi_sel)          hi_run_q <= hi_run_q + HW'(1);
    end

    assert_bc_dec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |=> (bc_out == $past(bc_out) - CNT_W'(1)));

    assert_pv_nz_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |=> (pv_flag == (bc_out != '0)));

    assert_cmp_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && cmp_q && zf_q) |=> !addr_hi_sel);

    assert_rewind_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_hi_sel) |-> (pc_out == $past(pc_out) - REWIND &&
                                memptr_out == pc_out + ADDR_W'(1)));

    assert_stall_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_hi_sel) |-> (hi_run_q == HW'(STALL_CYC)));

    assert_short_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE && !go_long) |=> $stable(memptr_out) && $stable(pc_out));

    assert_wait_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAITCHK && wait_in) |=> !done);

    assert_done_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
endmodule

// File: tb/blkrep_ctrl_tb_top.sv
module blkrep_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, is_cmp = 1'b0, rep_mode = 1'b0, zf_in = 1'b0, wait_in = 1'b0;
    logic [15:0] bc_in = '0, pc_in = '0;
    logic [15:0] bc_out, pc_out, memptr_out;
    logic        pv_flag, addr_hi_sel, busy, repeat_taken, fetch_go, done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    blkrep_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .is_cmp(is_cmp),
        .rep_mode(rep_mode), .zf_in(zf_in), .bc_in(bc_in), .pc_in(pc_in),
        .wait_in(wait_in), .bc_out(bc_out), .pv_flag(pv_flag), .pc_out(pc_out),
        .memptr_out(memptr_out), .addr_hi_sel(addr_hi_sel), .busy(busy),
        .repeat_taken(repeat_taken), .fetch_go(fetch_go), .done(done)
    );

    // {is_cmp, rep_mode, zf, bc[15:0], pc[15:0], expected_repeat}
    localparam int NV = 9;
    localparam logic [35:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 16'h0005, 16'h1000, 1'b1},
        {1'b0, 1'b1, 1'b0, 16'h0001, 16'h2000, 1'b0},
        {1'b0, 1'b0, 1'b0, 16'h0005, 16'h3000, 1'b0},
        {1'b1, 1'b1, 1'b0, 16'h0003, 16'h4000, 1'b1},
        {1'b1, 1'b1, 1'b1, 16'h0003, 16'h5000, 1'b0},
        {1'b1, 1'b1, 1'b1, 16'h0001, 16'h6000, 1'b0},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h7002, 1'b1},
        {1'b1, 1'b0, 1'b0, 16'h0002, 16'h8000, 1'b0},
        {1'b0, 1'b1, 1'b1, 16'h0002, 16'h0001, 1'b1}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic cmp, input logic rep, input logic zf,
                          input logic [15:0] bc, input logic [15:0] pc, input int wcyc,
                          output int lat, output int hic, output int gap);
        @(negedge clk);
        start = 1'b1; is_cmp = cmp; rep_mode = rep; zf_in = zf;
        bc_in = bc; pc_in = pc; wait_in = 1'b1;
        lat = 0; hic = 0; gap = 0;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            start = 1'b0;
            wait_in = (k < 2 + wcyc);
            if (addr_hi_sel) hic++;
            if (!busy) gap++;
            if (done) begin
                lat = k;
                break;
            end
        end
        wait_in = 1'b0;
        if (lat == 0) check(1'b0, "R9 watchdog", 0, 1);
    endtask

    initial begin
        #2_000_000;
        check(1'b0, "R9 global watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] model_mp;
        int lat, hic, gap;

        // reset state (R9)
        repeat (3) @(negedge clk);
        check(bc_out == 0 && pc_out == 0 && memptr_out == 0, "R9 reset regs",
              {bc_out, pc_out}, 0);
        check(!pv_flag && !busy && !done && !fetch_go && !addr_hi_sel && !repeat_taken,
              "R9 reset flags", {pv_flag, busy, done, fetch_go, addr_hi_sel}, 0);
        rst_n = 1'b1;
        model_mp = 16'h0000;

        for (int i = 0; i < NV; i++) begin
            logic        c, r, z, er, mrep;
            logic [15:0] b, p, nb;
            {c, r, z, b, p, er} = VEC[i];
            nb = b - 16'h1;
            mrep = r && (nb != 0) && !(c && z);
            run_op(c, r, z, b, p, 0, lat, hic, gap);
            check(bc_out == nb, $sformatf("R1 vec%0d bc", i), bc_out, nb);
            check(pv_flag == (nb != 0), $sformatf("R2 vec%0d pv", i), pv_flag, nb != 0);
            check(repeat_taken == er && er == mrep,
                  $sformatf("%s vec%0d repeat", c ? "R4" : "R3", i), repeat_taken, er);
            if (er) begin
                model_mp = p - 16'h1;
                check(pc_out == p - 16'h2, $sformatf("R5 vec%0d pc", i), pc_out, p - 16'h2);
                check(memptr_out == model_mp, $sformatf("R5 vec%0d memptr", i), memptr_out, model_mp);
                check(hic == 5, $sformatf("R6 vec%0d stall cycles", i), hic, 5);
                check(lat == 8, $sformatf("R6 vec%0d latency", i), lat, 8);
            end else begin
                check(pc_out == p, $sformatf("R7 vec%0d pc kept", i), pc_out, p);
                check(memptr_out == model_mp, $sformatf("R7 vec%0d memptr kept", i), memptr_out, model_mp);
                check(hic == 0, $sformatf("R7 vec%0d no stall", i), hic, 0);
                check(lat == 3, $sformatf("R6 vec%0d short latency", i), lat, 3);
            end
            check(gap == 0 && fetch_go, $sformatf("R9 vec%0d busy/fetch", i), {gap, fetch_go}, 1);
            @(negedge clk);
            check(!done && !busy && !fetch_go, $sformatf("R9 vec%0d single done", i),
                  {done, busy, fetch_go}, 0);
        end

        // wait-state delay on the short ending (R8)
        run_op(1'b0, 1'b0, 1'b0, 16'h0010, 16'h0ABC, 3, lat, hic, gap);
        check(lat == 6, "R8 short with 3 wait cycles", lat, 6);
        check(gap == 0, "R9 busy during wait", gap, 0);

        // wait on the long ending, active across stall into the check state (R8)
        run_op(1'b0, 1'b1, 1'b0, 16'h0010, 16'h0100, 7, lat, hic, gap);
        check(lat == 10, "R8 long with wait overlap", lat, 10);
        check(hic == 5, "R6 stall unchanged by wait", hic, 5);

        // start while busy is ignored (R9): stray pulse mid-sequence
        @(negedge clk);
        start = 1'b1; is_cmp = 1'b0; rep_mode = 1'b1; zf_in = 1'b0;
        bc_in = 16'h0004; pc_in = 16'h0200; wait_in = 1'b0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        bc_in = 16'h0077; pc_in = 16'h0999;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check(bc_out == 16'h0003 && pc_out == 16'h01FE, "R9 start ignored while busy",
              {bc_out, pc_out}, {16'h0003, 16'h01FE});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule